// File: doc/BRIEF.md
# Clock-crossing control register with soft reset and enable handshake

This block holds the main control word of a peripheral whose engine runs on its own clock. Software reaches the word over a simple register port on the bus clock. Two of its bits are commands that must reach the peripheral clock domain: the run (enable) bit and the soft-reset bit. Each command travels over its own toggle request/acknowledge link, with a multi-flop synchronizer in each direction. A busy flag stays up in the bus domain until the acknowledge has come back.

The configuration field is used directly in the bus domain and does not pass through a synchronizer. It can only be written while the block is not running. A second register holds debug settings. A soft reset does not clear it. A write-protect input blocks all writes. When a soft reset completes, the block clears the control word, drives the peripheral enable low, gives one peripheral-clock reset pulse, and gives one bus-clock clear pulse for the peripheral's other registers.

Top module: `wsc_ctrl_reg`

## Requirements
- R1: After the asynchronous reset, the control word, debug register, both busy flags, clear pulse and peripheral enable are all 0.
- R2: A write made while `wprot_i` is 1 changes neither register and starts no handshake.
- R3: A write to the control word (`sel_i`=0) without bit 1 set puts bit 0 into `run_o` on the next bus clock and raises `busy_en_o` at the same time. Once `busy_en_o` falls, `p_en_o` equals `run_o`.
- R4: The configuration field (control word bits [CFG_W+1:2]) takes the written value only when `run_o` was 0 before the write. Bits 0 and 1 are never blocked by `run_o`.
- R5: A control write with bit 1 set discards every other bit of that write. From the next clock until the reset completes, control-word bit 1 and `busy_sr_o` both read 1.
- R6: When a soft reset completes, the following happen on the same bus edge: `run_o` and `cfg_o` clear, `busy_sr_o` and control bit 1 drop, and `clr_o` pulses for one cycle. Before that edge, `p_srst_o` has pulsed once and `p_en_o` has gone to 0.
- R7: The debug register (`sel_i`=1, low DBG_W bits) is written whenever writes are not blocked. A soft reset leaves it unchanged.
- R8: Writing 0 to control bit 1 starts no reset.
- R9: A run write that arrives while `busy_en_o` is 1 reads back at once. It is held and sent once the link is free. After `busy_en_o` falls, `p_en_o` equals the last value written.
- R10: A soft-reset write that arrives while a reset is in progress is held. It produces a second full reset with a second `p_srst_o` and `clr_o` pulse.
- R11: While a reset is in progress, control writes without bit 1 set are ignored.
- R12: The configuration field appears on `cfg_o` one bus clock after the write, with no synchronizer delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| pclk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_i | input | 1 | Write strobe |
| sel_i | input | 1 | Register select: 0 control word, 1 debug register |
| wdata_i | input | DATA_W | Write data |
| wprot_i | input | 1 | Write protect; blocks all writes while 1 |
| rdata_o | output | DATA_W | Read data of the selected register (combinational) |
| run_o | output | 1 | Run bit as read back in the bus domain |
| cfg_o | output | CFG_W | Configuration field |
| dbg_o | output | DBG_W | Debug register |
| busy_en_o | output | 1 | Run command pending or in flight |
| busy_sr_o | output | 1 | Soft reset pending or in flight |
| clr_o | output | 1 | One-cycle clear for the peripheral's other registers |
| p_en_o | output | 1 | Enable in the peripheral domain |
| p_srst_o | output | 1 | One-cycle reset pulse in the peripheral domain |

## Verification
The bench builds the block with DATA_W=16, CFG_W=6, DBG_W=5 and SYNC_STAGES=3. The peripheral clock period is 7 ns against the 5 ns bus clock. A narrow field lets random writes hit protected and unprotected cases and repeated configuration values often. Three stages stretch each handshake, so back-to-back run writes and a reset written during a reset land inside the busy window. The unrelated clock ratio moves the acknowledge return across different bus-cycle phases.

// File: rtl/wsc_pkg.sv
`timescale 1ns/1ps
package wsc_pkg;
  localparam int RUN_BIT  = 0;
  localparam int SRST_BIT = 1;
  localparam int CFG_LSB  = 2;
  localparam int CH_EN    = 0;
  localparam int CH_SR    = 1;
  localparam int N_CH     = 2;

  typedef enum logic [0:0] {
    SEL_CTRL = 1'b0,
    SEL_DBG  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/wsc_toggle_link.sv
`timescale 1ns/1ps
// Toggle request crosses to the peripheral clock; toggle acknowledge comes back.
module wsc_toggle_link #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic pclk,
  input  logic rst_n,
  input  logic launch_i,
  output logic busy_o,
  output logic evt_o
);
  logic              req_q, req_d;
  logic [STAGES-1:0] fwd_q;
  logic              ack_q;
  logic [STAGES-1:0] back_q;

  always_comb begin
    req_d = req_q;
    if (launch_i) req_d = ~req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      back_q <= '0;
    end else begin
      req_q  <= req_d;
      back_q <= {back_q[STAGES-2:0], ack_q};
    end
  end

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_q <= '0;
      ack_q <= 1'b0;
    end else begin
      fwd_q <= {fwd_q[STAGES-2:0], req_q};
      ack_q <= fwd_q[STAGES-1];
    end
  end

  assign evt_o  = fwd_q[STAGES-1] ^ ack_q;
  assign busy_o = req_q ^ back_q[STAGES-1];
endmodule

// File: rtl/wsc_periph_apply.sv
`timescale 1ns/1ps
// Peripheral-domain side: applies enable and soft-reset events.
module wsc_periph_apply (
  input  logic pclk,
  input  logic rst_n,
  input  logic en_evt_i,
  input  logic sr_evt_i,
  input  logic en_val_i,
  output logic en_o,
  output logic srst_o
);
  logic en_q, en_d;
  logic srst_q;

  always_comb begin
    en_d = en_q;
    if (sr_evt_i)      en_d = 1'b0;
    else if (en_evt_i) en_d = en_val_i;
  end

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      srst_q <= sr_evt_i;
    end
  end

  assign en_o   = en_q;
  assign srst_o = srst_q;
endmodule

// File: rtl/wsc_ctrl_reg.sv
`timescale 1ns/1ps
module wsc_ctrl_reg
  import wsc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CFG_W       = 16,
  parameter int DBG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              pclk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wprot_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              run_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [DBG_W-1:0]  dbg_o,
  output logic              busy_en_o,
  output logic              busy_sr_o,
  output logic              clr_o,
  output logic              p_en_o,
  output logic              p_srst_o
);
  localparam int CFG_MSB = CFG_LSB + CFG_W - 1;

  logic             run_q, run_d;
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic [DBG_W-1:0] dbg_q, dbg_d;
  logic             pend_en_q, pend_en_d;
  logic             pend_sr_q, pend_sr_d;
  logic             fly_sr_q, fly_sr_d;
  logic             en_val_q, en_val_d;
  logic             clr_q, clr_d;

  logic [N_CH-1:0]  launch, link_busy, link_evt;
  logic             wr_ok, ctrl_wr, dbg_wr, sr_req, plain_wr, sr_active, sr_done;
  logic             unused_wbits;

  assign wr_ok     = wr_en_i & ~wprot_i;
  assign ctrl_wr   = wr_ok & (reg_sel_e'(sel_i) == SEL_CTRL);
  assign dbg_wr    = wr_ok & (reg_sel_e'(sel_i) == SEL_DBG);
  assign sr_active = pend_sr_q | fly_sr_q;
  assign sr_req    = ctrl_wr & wdata_i[SRST_BIT];
  assign plain_wr  = ctrl_wr & ~wdata_i[SRST_BIT] & ~sr_active;
  assign sr_done   = fly_sr_q & ~link_busy[CH_SR];

  assign launch[CH_EN] = pend_en_q & ~link_busy[CH_EN];
  assign launch[CH_SR] = pend_sr_q & ~fly_sr_q;

  assign unused_wbits = ^wdata_i;

  always_comb begin
    run_d     = run_q;
    cfg_d     = cfg_q;
    pend_en_d = pend_en_q;
    pend_sr_d = pend_sr_q;
    fly_sr_d  = fly_sr_q;
    en_val_d  = en_val_q;
    clr_d     = 1'b0;
    if (launch[CH_EN]) begin
      pend_en_d = 1'b0;
      en_val_d  = run_q;
    end
    if (plain_wr) begin
      run_d     = wdata_i[RUN_BIT];
      pend_en_d = 1'b1;
      if (!run_q) cfg_d = wdata_i[CFG_MSB:CFG_LSB];
    end
    if (launch[CH_SR]) begin
      pend_sr_d = 1'b0;
      fly_sr_d  = 1'b1;
    end
    if (sr_done) begin
      fly_sr_d = 1'b0;
      run_d    = 1'b0;
      cfg_d    = '0;
      clr_d    = 1'b1;
    end
    if (sr_req) begin
      pend_sr_d = 1'b1;
      pend_en_d = 1'b0;
    end
  end

  always_comb begin
    dbg_d = dbg_q;
    if (dbg_wr) dbg_d = wdata_i[DBG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      cfg_q     <= '0;
      dbg_q     <= '0;
      pend_en_q <= 1'b0;
      pend_sr_q <= 1'b0;
      fly_sr_q  <= 1'b0;
      en_val_q  <= 1'b0;
      clr_q     <= 1'b0;
    end else begin
      run_q     <= run_d;
      cfg_q     <= cfg_d;
      dbg_q     <= dbg_d;
      pend_en_q <= pend_en_d;
      pend_sr_q <= pend_sr_d;
      fly_sr_q  <= fly_sr_d;
      en_val_q  <= en_val_d;
      clr_q     <= clr_d;
    end
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_link
    wsc_toggle_link #(.STAGES(SYNC_STAGES)) u_link (
      .clk      (clk),
      .pclk     (pclk),
      .rst_n    (rst_n),
      .launch_i (launch[ch]),
      .busy_o   (link_busy[ch]),
      .evt_o    (link_evt[ch])
    );
  end

  wsc_periph_apply u_apply (
    .pclk     (pclk),
    .rst_n    (rst_n),
    .en_evt_i (link_evt[CH_EN]),
    .sr_evt_i (link_evt[CH_SR]),
    .en_val_i (en_val_q),
    .en_o     (p_en_o),
    .srst_o   (p_srst_o)
  );

  always_comb begin
    rdata_o = '0;
    if (reg_sel_e'(sel_i) == SEL_CTRL) begin
      rdata_o[RUN_BIT]         = run_q;
      rdata_o[SRST_BIT]        = sr_active;
      rdata_o[CFG_MSB:CFG_LSB] = cfg_q;
    end else begin
      rdata_o[DBG_W-1:0] = dbg_q;
    end
  end

  assign run_o     = run_q;
  assign cfg_o     = cfg_q;
  assign dbg_o     = dbg_q;
  assign busy_en_o = pend_en_q | link_busy[CH_EN];
  assign busy_sr_o = sr_active;
  assign clr_o     = clr_q;
endmodule

// File: rtl/wsc_ctrl_reg_chk.sv
`timescale 1ns/1ps
module wsc_ctrl_reg_chk
  import wsc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CFG_W  = 16,
  parameter int DBG_W  = 8
) (
  input logic              clk,
  input logic              pclk,
  input logic              rst_n,
  input logic              wr_en_i,
  input logic              sel_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              wprot_i,
  input logic              run_o,
  input logic [CFG_W-1:0]  cfg_o,
  input logic [DBG_W-1:0]  dbg_o,
  input logic              busy_en_o,
  input logic              busy_sr_o,
  input logic              clr_o,
  input logic              p_en_o,
  input logic              p_srst_o
);
  logic ctrl_acc;
  assign ctrl_acc = wr_en_i && !wprot_i && (sel_i == 1'b0);

  // R2
  wprot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && wprot_i && !busy_sr_o |=> $stable(run_o) && $stable(cfg_o) && $stable(dbg_o));

  // R3
  run_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_acc && !wdata_i[SRST_BIT] && !busy_sr_o |=> run_o == $past(wdata_i[RUN_BIT]) && busy_en_o);

  // R4
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_acc && !wdata_i[SRST_BIT] && !busy_sr_o && run_o |=> $stable(cfg_o));

  // R5
  srst_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_acc && wdata_i[SRST_BIT] && !busy_sr_o |=> busy_sr_o && $stable(run_o) && $stable(cfg_o));

  // R6
  clr_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |-> !run_o && cfg_o == '0);

  // R6
  busy_drop_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_sr_o) |-> clr_o);

  // R6
  periph_srst_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    p_srst_o |-> !p_en_o);

  // R7
  dbg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o && !$past(wr_en_i && sel_i) |-> $stable(dbg_o));
endmodule

bind wsc_ctrl_reg wsc_ctrl_reg_chk #(
  .DATA_W (DATA_W),
  .CFG_W  (CFG_W),
  .DBG_W  (DBG_W)
) u_chk (
  .clk       (clk),
  .pclk      (pclk),
  .rst_n     (rst_n),
  .wr_en_i   (wr_en_i),
  .sel_i     (sel_i),
  .wdata_i   (wdata_i),
  .wprot_i   (wprot_i),
  .run_o     (run_o),
  .cfg_o     (cfg_o),
  .dbg_o     (dbg_o),
  .busy_en_o (busy_en_o),
  .busy_sr_o (busy_sr_o),
  .clr_o     (clr_o),
  .p_en_o    (p_en_o),
  .p_srst_o  (p_srst_o)
);

// File: tb/test_wsc_ctrl_reg.sv
`timescale 1ns/1ps
module test_wsc_ctrl_reg;
  localparam int DATA_W = 16;
  localparam int CFG_W  = 6;
  localparam int DBG_W  = 5;

  logic clk = 1'b0, pclk = 1'b0, rst_n = 1'b0;
  logic wr_en_i = 1'b0, sel_i = 1'b0, wprot_i = 1'b0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic run_o, busy_en_o, busy_sr_o, clr_o, p_en_o, p_srst_o;
  logic [CFG_W-1:0] cfg_o;
  logic [DBG_W-1:0] dbg_o;

  int n_chk = 0, n_fail = 0, clr_cnt = 0, srst_cnt = 0;
  bit done = 0;
  logic m_run;
  logic [CFG_W-1:0] m_cfg;
  logic [DBG_W-1:0] m_dbg;

  always #2.5 clk = ~clk;
  always #3.5 pclk = ~pclk;

  wsc_ctrl_reg #(.DATA_W(DATA_W), .CFG_W(CFG_W), .DBG_W(DBG_W), .SYNC_STAGES(3)) i_wsc_ctrl_reg (
    .clk(clk), .pclk(pclk), .rst_n(rst_n), .wr_en_i(wr_en_i), .sel_i(sel_i),
    .wdata_i(wdata_i), .wprot_i(wprot_i), .rdata_o(rdata_o), .run_o(run_o),
    .cfg_o(cfg_o), .dbg_o(dbg_o), .busy_en_o(busy_en_o), .busy_sr_o(busy_sr_o),
    .clr_o(clr_o), .p_en_o(p_en_o), .p_srst_o(p_srst_o));

  always @(negedge clk)  if (rst_n && clr_o)    clr_cnt++;
  always @(negedge pclk) if (rst_n && p_srst_o) srst_cnt++;

  function automatic logic [DATA_W-1:0] ctrl_word(logic run, logic sr, logic [CFG_W-1:0] cfg);
    logic [DATA_W-1:0] w;
    w = '0;
    w[0] = run;
    w[1] = sr;
    w[CFG_W+1:2] = cfg;
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic wr(input logic sel, input logic [DATA_W-1:0] d, input logic prot);
    @(negedge clk);
    wr_en_i = 1'b1; sel_i = sel; wdata_i = d; wprot_i = prot;
    @(negedge clk);
    wr_en_i = 1'b0; wprot_i = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [DATA_W-1:0] d);
    sel_i = sel;
    #0.5;
    d = rdata_o;
  endtask

  task automatic wait_idle(input string tag);
    bit idle = 0;
    for (int i = 0; i < 400 && !idle; i++) begin
      @(negedge clk);
      idle = !busy_en_o && !busy_sr_o;
    end
    chk(idle, {tag, " handshake finishes"}, {busy_en_o, busy_sr_o}, 0);
    #1;
  endtask

  task automatic check_state(input string tag);
    logic [DATA_W-1:0] r;
    rd(1'b0, r);
    chk(r == ctrl_word(m_run, 1'b0, m_cfg), {tag, " control word"}, r, ctrl_word(m_run, 1'b0, m_cfg));
    rd(1'b1, r);
    chk(r == DATA_W'(m_dbg), {tag, " debug reg"}, r, m_dbg);
    chk(p_en_o == m_run, {tag, " peripheral enable"}, p_en_o, m_run);
  endtask

  task automatic do_reset_idle(input string tag);
    int c0, s0;
    c0 = clr_cnt; s0 = srst_cnt;
    wr(1'b0, ctrl_word(1'b1, 1'b1, '1), 1'b0);
    wait_idle(tag);
    m_run = 1'b0; m_cfg = '0;
    chk(clr_cnt == c0 + 1, "R6 one clear pulse", clr_cnt - c0, 1);
    chk(srst_cnt == s0 + 1, "R6 one peripheral reset pulse", srst_cnt - s0, 1);
    check_state("R6 after reset");
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    logic [DATA_W-1:0] r, d;
    int c0, s0;
    void'($urandom(32'd1234));
    m_run = 0; m_cfg = '0; m_dbg = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check_state("R1");
    chk(!busy_en_o && !busy_sr_o && !clr_o, "R1 flags", {busy_en_o, busy_sr_o, clr_o}, 0);

    // R8 plain write, reset bit 0
    wr(1'b0, ctrl_word(1'b1, 1'b0, 6'h15), 1'b0);
    chk(!busy_sr_o, "R8 no reset started", busy_sr_o, 0);
    chk(busy_en_o, "R3 enable busy raised", busy_en_o, 1);
    m_run = 1; m_cfg = 6'h15;
    wait_idle("R3");
    check_state("R3");

    // R4 protected field
    wr(1'b0, ctrl_word(1'b1, 1'b0, 6'h2a), 1'b0);
    chk(cfg_o == 6'h15, "R4 cfg frozen while running", cfg_o, 6'h15);
    wr(1'b0, ctrl_word(1'b0, 1'b0, 6'h2a), 1'b0);
    chk(cfg_o == 6'h15 && !run_o, "R4 disable write keeps cfg", {run_o, cfg_o}, 6'h15);
    wr(1'b0, ctrl_word(1'b0, 1'b0, 6'h2a), 1'b0);
    chk(cfg_o == 6'h2a, "R4 cfg writable when stopped", cfg_o, 6'h2a);
    m_run = 0; m_cfg = 6'h2a;
    wait_idle("R4");
    check_state("R4");

    // R2 write protect
    wr(1'b0, ctrl_word(1'b1, 1'b1, 6'h3f), 1'b1);
    wr(1'b1, 16'h1f, 1'b1);
    chk(!busy_en_o && !busy_sr_o, "R2 no handshake", {busy_en_o, busy_sr_o}, 0);
    check_state("R2");

    // R7 debug then reset
    wr(1'b1, 16'h0b, 1'b0);
    m_dbg = 5'h0b;
    wr(1'b0, ctrl_word(1'b1, 1'b0, 6'h07), 1'b0);
    m_run = 1; m_cfg = 6'h07;
    wait_idle("R7 pre");
    // R5 other fields discarded
    wr(1'b0, ctrl_word(1'b0, 1'b1, 6'h30), 1'b0);
    rd(1'b0, r);
    chk(r == ctrl_word(1'b1, 1'b1, 6'h07), "R5 discard and busy bit", r, ctrl_word(1'b1, 1'b1, 6'h07));
    chk(busy_sr_o, "R5 reset busy", busy_sr_o, 1);
    c0 = clr_cnt; s0 = srst_cnt;
    wait_idle("R5");
    m_run = 0; m_cfg = '0;
    chk(clr_cnt == c0 + 1 && srst_cnt == s0 + 1, "R6 pulses", {clr_cnt - c0, srst_cnt - s0}, 2'b11);
    check_state("R7 debug kept");

    // R9 back-to-back run writes
    wr(1'b0, ctrl_word(1'b1, 1'b0, 6'h01), 1'b0);
    wr(1'b0, ctrl_word(1'b0, 1'b0, 6'h02), 1'b0);
    chk(!run_o && busy_en_o, "R9 readback during busy", {run_o, busy_en_o}, 2'b01);
    wr(1'b0, ctrl_word(1'b1, 1'b0, 6'h03), 1'b0);
    chk(run_o, "R9 latest readback", run_o, 1);
    m_run = 1; m_cfg = 6'h03;
    wait_idle("R9");
    check_state("R9");

    // R10 / R11 reset during reset
    c0 = clr_cnt; s0 = srst_cnt;
    wr(1'b0, ctrl_word(1'b0, 1'b1, '0), 1'b0);
    wr(1'b0, ctrl_word(1'b0, 1'b0, 6'h11), 1'b0);
    chk(run_o && cfg_o == 6'h03, "R11 write ignored in reset", {run_o, cfg_o}, {1'b1, 6'h03});
    wr(1'b0, ctrl_word(1'b0, 1'b1, '0), 1'b0);
    wait_idle("R10");
    m_run = 0; m_cfg = '0;
    chk(clr_cnt == c0 + 2, "R10 two clear pulses", clr_cnt - c0, 2);
    chk(srst_cnt == s0 + 2, "R10 two peripheral resets", srst_cnt - s0, 2);
    check_state("R10");

    // random mix
    for (int it = 0; it < 60; it++) begin
      int op;
      op = $urandom % 8;
      d = DATA_W'($urandom);
      if (op == 0) begin
        wr(d[0], d, 1'b1);
        chk(!busy_en_o && !busy_sr_o, "R2 random protect", {busy_en_o, busy_sr_o}, 0);
        check_state("R2 random");
      end else if (op == 1) begin
        wr(1'b1, d, 1'b0);
        m_dbg = d[DBG_W-1:0];
        check_state("R7 random debug");
      end else if (op == 2) begin
        do_reset_idle("R6 random");
      end else begin
        d[1] = 1'b0;
        wr(1'b0, d, 1'b0);
        if (!m_run) m_cfg = d[CFG_W+1:2];
        m_run = d[0];
        chk(cfg_o == m_cfg, "R12 cfg next cycle", cfg_o, m_cfg);
        chk(run_o == m_run && busy_en_o, "R3 random readback", {run_o, busy_en_o}, {m_run, 1'b1});
        wait_idle("R3 random");
        check_state("R3 random");
      end
    end
    report();
  end
endmodule